// File: doc/BRIEF.md
# Modulo Alarm Timer

This block is a one-shot alarm source built around a 16-bit up-counter. Software programs a start value and a limit, selects the fixed-rate tick as the count source and picks a power-of-two divider. The counter then advances once per divided tick. When it has reached the limit, the next counted tick reloads it with the start value and latches an overflow flag. If the overflow interrupt enable is set, the flag drives a level interrupt. An alarm of N counted ticks uses a start value of 0 and a limit of N-1.

The registers are reached through a simple 32-bit request port. A request is offered with `bus_valid`. `bus_ready` is tied high, so the block never applies back-pressure and every offered request is taken on the edge where it is sampled. An accepted read returns its data one cycle later, marked by a single-cycle `resp_valid`. The response path has no back-pressure, so the requester must be able to take it.

The offsets are: control/status 0x00, count 0x04, limit 0x08, start value 0x4C. The control/status register has these fields: bits [2:0] divider exponent, bits [4:3] source select, bit 5 reserved (reads 0), bit 6 overflow interrupt enable, bit 7 overflow flag. Only source select value 2 counts the tick input.

Top module: `modulo_alarm_timer`

## Requirements
- R1: After reset the control/status, count, limit and start registers all read 0, and `irq` is low.
- R2: Count, limit and start hold only their low 16 bits. Bits [31:16] read as 0 and writes to them are dropped. A read of any offset other than 0x00, 0x04, 0x08 or 0x4C returns 0.
- R3: A write of any data to the count register (0x04) does not store that data. It loads the counter with the current start value.
- R4: When source select is not 2, `tick_in` has no effect and the counter holds its value. The divider is cleared while source select is not 2.
- R5: With divider exponent p and source select 2, the counter advances once every 2^p pulses of `tick_in`. The first advance after enabling comes on the 2^p-th pulse.
- R6: On a counted tick with count equal to the limit, the counter reloads with the start value and the overflow flag (bit 7) sets. On any other counted tick the counter increments by one.
- R7: `irq` is high exactly while the overflow flag and the interrupt enable (bit 6) are both 1. Clearing the enable drops `irq` and leaves the flag set.
- R8: The flag clears only when 0 is written to bit 7 after a control/status read has returned bit 7 as 1. Writing 1 to bit 7, or writing 0 without such a prior read, leaves the flag unchanged.
- R9: If an overflow occurs in the same cycle as a valid clearing write, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_in | input | 1 | Fixed-rate tick enable, one cycle per tick |
| bus_valid | input | 1 | Register request offered |
| bus_ready | output | 1 | Request accepted (always 1) |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| resp_valid | output | 1 | Read data valid, one cycle after the read is accepted |
| resp_rdata | output | 32 | Read data |
| irq | output | 1 | Level overflow interrupt |

## Verification
A register write takes effect at the clock edge that accepts it. Read data appears after the next edge and stays for one cycle. The counter and the flag change at the same edge that samples a qualifying `tick_in`, and `irq` follows the flag with no added register. The bench drives every request and tick at a falling edge and samples at the following falling edge. Each result is therefore read exactly one edge after its cause, with no dependence on process order.

// File: rtl/alarm_tmr_pkg.sv
package alarm_tmr_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_LIMIT = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_START = 8'h4C;
  localparam int FLAG_BIT = 7;
  localparam logic [1:0] SRC_TICK = 2'd2;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       rsv;
    logic [1:0] src;
    logic [2:0] ps;
  } ctrl_t;
endpackage

// File: rtl/atm_prescaler.sv
module atm_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick_in,
  input  logic [PS_W-1:0] ps_sel,
  output logic            cnt_tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  // low ps_sel bits set: the divider passes a tick when they are all ones
  always_comb mask = ~({DIV_W{1'b1}} << ps_sel);

  assign cnt_tick = run && tick_in && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) div_q <= '0;
    else if (tick_in)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/atm_counter.sv
module atm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] start_val,
  input  logic [CNT_W-1:0] limit_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt
);
  // a load request takes the cycle; no overflow is raised alongside it
  assign wrap_evt = cnt_tick && !load && (cnt_q == limit_val);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= start_val;
    else if (wrap_evt) cnt_q <= start_val;
    else if (cnt_tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/atm_regs.sv
module atm_regs
  import alarm_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              wrap_evt,
  output ctrl_t             ctrl_q,
  output logic              load_cnt,
  output logic [CNT_W-1:0]  start_q,
  output logic [CNT_W-1:0]  limit_q
);
  logic wr_en, rd_en, wr_ctrl, rd_ctrl, arm_q, clr_ok;
  logic [DATA_W-1:0] rd_mux;

  assign wr_en    = bus_valid && bus_write;
  assign rd_en    = bus_valid && !bus_write;
  assign wr_ctrl  = wr_en && (bus_addr == OFS_CTRL);
  assign rd_ctrl  = rd_en && (bus_addr == OFS_CTRL);
  assign load_cnt = wr_en && (bus_addr == OFS_COUNT);
  assign clr_ok   = wr_ctrl && !bus_wdata[FLAG_BIT] && arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      arm_q   <= 1'b0;
      start_q <= '0;
      limit_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.ps  <= bus_wdata[2:0];
        ctrl_q.src <= bus_wdata[4:3];
        ctrl_q.ie  <= bus_wdata[6];
      end
      // a new overflow wins over a clear in the same cycle
      if (wrap_evt)    ctrl_q.flag <= 1'b1;
      else if (clr_ok) ctrl_q.flag <= 1'b0;
      if (clr_ok)                  arm_q <= 1'b0;
      else if (rd_ctrl && ctrl_q.flag) arm_q <= 1'b1;
      if (wr_en && bus_addr == OFS_LIMIT) limit_q <= bus_wdata[CNT_W-1:0];
      if (wr_en && bus_addr == OFS_START) start_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL:  rd_mux = DATA_W'(ctrl_q);
      OFS_COUNT: rd_mux = DATA_W'(cnt_val);
      OFS_LIMIT: rd_mux = DATA_W'(limit_q);
      OFS_START: rd_mux = DATA_W'(start_q);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= rd_en;
      if (rd_en) resp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/modulo_alarm_timer.sv
module modulo_alarm_timer
  import alarm_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic             load_cnt, cnt_tick, wrap_evt, run;
  logic [CNT_W-1:0] start_q, limit_q, cnt_q;

  assign bus_ready = 1'b1;
  assign run       = (ctrl_q.src == SRC_TICK);
  assign irq       = ctrl_q.flag && ctrl_q.ie;

  atm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .cnt_val(cnt_q), .wrap_evt(wrap_evt),
    .ctrl_q(ctrl_q), .load_cnt(load_cnt),
    .start_q(start_q), .limit_q(limit_q)
  );

  atm_prescaler #(.PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick_in(tick_in),
    .ps_sel(ctrl_q.ps[PS_W-1:0]), .cnt_tick(cnt_tick)
  );

  atm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .load(load_cnt),
    .start_val(start_q), .limit_val(limit_q),
    .cnt_q(cnt_q), .wrap_evt(wrap_evt)
  );
endmodule

// File: rtl/atm_checker.sv
module atm_checker
  import alarm_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  start_val,
  input logic [1:0]        src,
  input logic              flag,
  input logic              wrap_evt
);
  logic cnt_wr, ctrl_clr_wr;
  assign cnt_wr      = bus_valid && bus_write && (bus_addr == OFS_COUNT);
  assign ctrl_clr_wr = bus_valid && bus_write && (bus_addr == OFS_CTRL) && !bus_wdata[FLAG_BIT];

  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(start_val)));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_TICK && !cnt_wr) |=> $stable(cnt));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (cnt == $past(start_val)));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag);

  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(ctrl_clr_wr));
endmodule

bind modulo_alarm_timer atm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt_q),
  .start_val(start_q), .src(ctrl_q.src), .flag(ctrl_q.flag),
  .wrap_evt(wrap_evt)
);

// File: tb/sim_modulo_alarm_timer.sv
`timescale 1ns/1ps
module sim_modulo_alarm_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick_in = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_ready, resp_valid, irq;
  logic [31:0] resp_rdata;
  int n_chk = 0, n_fail = 0;

  localparam logic [7:0] A_SC = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_INI = 8'h4C;

  always #4 clk = ~clk;

  modulo_alarm_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .irq(irq)
  );

  function automatic logic [31:0] sc(input logic [1:0] src, input logic [2:0] ps,
                                     input logic ie, input logic keep);
    return {24'd0, keep, ie, 1'b0, src, ps};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; tick_in = tk;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; tick_in = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    chk("resp_valid", {31'd0, resp_valid}, 32'd1);
    d = resp_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(posedge clk);
      @(negedge clk); tick_in = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_SC, d);  chk("R1 ctrl", d, 0);
    rd(A_CNT, d); chk("R1 count", d, 0);
    rd(A_MOD, d); chk("R1 limit", d, 0);
    rd(A_INI, d); chk("R1 start", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 ready", {31'd0, bus_ready}, 1);
  endtask

  task automatic t_width();
    logic [31:0] d;
    wr(A_MOD, 32'hABCD_1234); rd(A_MOD, d); chk("R2 limit upper", d, 32'h1234);
    wr(A_INI, 32'hFFFF_0055); rd(A_INI, d); chk("R2 start upper", d, 32'h55);
    rd(8'h10, d); chk("R2 unmapped", d, 0);
  endtask

  task automatic t_load();
    logic [31:0] d;
    wr(A_CNT, 32'h0000_FFFF); rd(A_CNT, d); chk("R3 count load", d, 32'h55);
  endtask

  task automatic t_div();
    logic [31:0] d;
    wr(A_INI, 0); wr(A_MOD, 32'hFFFF); wr(A_CNT, 0);
    wr(A_SC, sc(2'd2, 3'd2, 1'b0, 1'b1));
    ticks(3); rd(A_CNT, d); chk("R5 before 4th", d, 0);
    ticks(1); rd(A_CNT, d); chk("R5 4th", d, 1);
    ticks(4); rd(A_CNT, d); chk("R5 8th", d, 2);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    wr(A_SC, sc(2'd0, 3'd2, 1'b0, 1'b1));
    ticks(5); rd(A_CNT, d); chk("R4 off", d, 2);
    wr(A_SC, sc(2'd1, 3'd0, 1'b0, 1'b1));
    ticks(3); rd(A_CNT, d); chk("R4 src1", d, 2);
  endtask

  task automatic t_reload();
    logic [31:0] d;
    wr(A_SC, sc(2'd0, 3'd0, 1'b0, 1'b1));
    wr(A_MOD, 2); wr(A_CNT, 0);
    wr(A_SC, sc(2'd2, 3'd0, 1'b0, 1'b1));
    ticks(2); rd(A_CNT, d); chk("R6 at limit", d, 2);
    chk("R6 no flag yet", {31'd0, irq}, 0);
    wr(A_SC, sc(2'd2, 3'd0, 1'b1, 1'b1));
    chk("R6 flag clear before wrap", {31'd0, irq}, 0);
    ticks(1); rd(A_CNT, d); chk("R6 wrapped", d, 0);
    chk("R6 flag via irq", {31'd0, irq}, 1);
    wr(A_INI, 5); wr(A_MOD, 6); wr(A_CNT, 32'h1234);
    rd(A_CNT, d); chk("R3 load start", d, 5);
    ticks(2); rd(A_CNT, d); chk("R6 reload start", d, 5);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    chk("R7 irq on", {31'd0, irq}, 1);
    wr(A_SC, sc(2'd2, 3'd0, 1'b0, 1'b1));
    chk("R7 irq off", {31'd0, irq}, 0);
    rd(A_SC, d); chk("R7 flag kept", {31'd0, d[7]}, 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A_SC, sc(2'd2, 3'd0, 1'b1, 1'b1));
    chk("R8 write1 keeps", {31'd0, irq}, 1);
    wr(A_SC, sc(2'd0, 3'd0, 1'b1, 1'b0));
    chk("R8 armed clear", {31'd0, irq}, 0);
    wr(A_INI, 0); wr(A_MOD, 0); wr(A_CNT, 0);
    wr(A_SC, sc(2'd2, 3'd0, 1'b1, 1'b1));
    ticks(1);
    chk("R8 new flag", {31'd0, irq}, 1);
    wr(A_SC, sc(2'd0, 3'd0, 1'b1, 1'b0));
    chk("R8 unarmed clear ignored", {31'd0, irq}, 1);
    rd(A_SC, d);
    wr(A_SC, sc(2'd0, 3'd0, 1'b0, 1'b0));
    rd(A_SC, d); chk("R8 cleared", {31'd0, d[7]}, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(A_MOD, 1); wr(A_CNT, 0);
    wr(A_SC, sc(2'd2, 3'd0, 1'b0, 1'b1));
    ticks(2);
    ticks(1); rd(A_CNT, d); chk("R9 at limit", d, 1);
    rd(A_SC, d); chk("R9 flag set", {31'd0, d[7]}, 1);
    wr(A_SC, sc(2'd2, 3'd0, 1'b0, 1'b0), 1'b1);
    rd(A_SC, d); chk("R9 set wins", {31'd0, d[7]}, 1);
    rd(A_CNT, d); chk("R9 wrapped", d, 0);
    wr(A_SC, sc(2'd0, 3'd0, 1'b0, 1'b0));
    rd(A_SC, d); chk("R9 later clear", {31'd0, d[7]}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset(); t_width(); t_load(); t_div(); t_hold();
    t_reload(); t_irq(); t_clear(); t_race();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule